// File: doc/BRIEF.md
# Switch-Configured Memory Address Decoder

This block decides whether a memory board claims an asynchronous bus transaction. When the bus sync strobe rises, it evaluates the address presented on the bus against eight configuration switches. It then holds a registered memory-request flag for the rest of the transaction. In the same cycle it captures the sixteen word-address bits A16..A1, which the DRAM row and column multiplexer uses later.

A mode input selects one of two decode schemes. In wide-address mode, address bits A21..A18 must equal a four-bit code taken from switches 1 to 4, which picks one fixed-size board slot. In narrow-address mode, address bits A17..A14 are compared against an inclusive window. Switches 1 to 4 give the first 16 KB block and switches 5 to 8 give the last. An active I/O-page select always overrides the decode and leaves the board unselected.

Top module: `addr_window_decoder`

## Requirements
- R1: While rst_n is low, mem_req_o is 0 and rowcol_addr_o is all zeros.
- R2: In wide mode (wide_mode_i = 1), a capture sets mem_req_o exactly when address bits A21..A18 equal the code of switches 1 to 4 (sw_on_i[3:0], switch 1 as bit 0).
- R3: In narrow mode (wide_mode_i = 0), a capture sets mem_req_o exactly when start <= A17..A14 <= end. Here start is the code of sw_on_i[3:0] and end is the code of sw_on_i[7:4]. The end block counts in full, so a start of 2 and an end of 14 claim bytes 32 KB through 240 KB - 1. Bits A21..A18 play no part in this mode.
- R4: In narrow mode, a start code greater than the end code selects no address.
- R5: If io_page_i is high at capture, mem_req_o stays 0 whatever the switches and address are.
- R6: A capture happens at the first rising clock edge where sync_i is sampled high after being low. mem_req_o shows the result from that edge onward and keeps it while sync_i stays high, even if the address then changes.
- R7: At the first rising edge where sync_i is sampled low, mem_req_o returns to 0.
- R8: rowcol_addr_o takes address bits A16..A1 at each capture and holds them at all other times.
- R9: A switch that is ON (sw_on_i bit = 1) reads as 0 in the code, so with all switches ON in wide mode the board claims address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Bus address strobe, synchronous to clk |
| addr_i | input | 21 | Byte address bits A21..A1 |
| wide_mode_i | input | 1 | 1: slot compare on A21..A18; 0: window compare on A17..A14 |
| sw_on_i | input | 8 | Switch positions, 1 = ON, switch 1 at bit 0 |
| io_page_i | input | 1 | I/O-page select; forces the board unselected |
| mem_req_o | output | 1 | Registered board-selected flag |
| rowcol_addr_o | output | 16 | A16..A1 captured at the sync rise |

## Verification
The assertions take for granted that sync_i already meets the clk timing. They also assume that the address, mode, switches and I/O-page select are steady in the cycle where the strobe is first sampled high. The stimulus changes every input at the falling clock edge, raises the strobe together with a settled address, and changes the address only after the capture edge, which exercises the hold behaviour. Switch settings and mode change only while the strobe is low.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  parameter int ADDR_W     = 22;
  parameter int FIELD_W    = 4;
  parameter int WIDE_LSB   = 18;
  parameter int NARROW_LSB = 14;
  parameter int ROWCOL_LO  = 1;
  parameter int ROWCOL_HI  = 16;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t last_blk;
    field_t first_blk;
  } sw_code_t;
endpackage

// File: rtl/ad_edge_detect.sv
module ad_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic rise_o
);
  logic level_q;
  logic level_d;

  always_comb begin
    level_d = sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign rise_o = sync_i & ~level_q;

  // R6: a capture is a one-cycle event per strobe
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ad_slot_match.sv
module ad_slot_match #(
  parameter int FIELD_W = 4
) (
  input  logic               wide_i,
  input  logic [FIELD_W-1:0] wide_field_i,
  input  logic [FIELD_W-1:0] narrow_field_i,
  input  logic [2*FIELD_W-1:0] sw_on_i,
  output logic               hit_o
);
  localparam int SW_W = 2*FIELD_W;

  logic [SW_W-1:0]    code;
  logic [FIELD_W-1:0] first_blk;
  logic [FIELD_W-1:0] last_blk;

  genvar g;
  generate
    for (g = 0; g < SW_W; g++) begin : g_sw
      assign code[g] = ~sw_on_i[g];
    end
  endgenerate

  assign first_blk = code[FIELD_W-1:0];
  assign last_blk  = code[SW_W-1:FIELD_W];

  always_comb begin
    if (wide_i) hit_o = (wide_field_i == first_blk);
    else        hit_o = (narrow_field_i >= first_blk) && (narrow_field_i <= last_blk);
  end
endmodule

// File: rtl/ad_capture.sv
module ad_capture #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             sync_i,
  input  logic             hit_i,
  input  logic             io_page_i,
  input  logic [LAT_W-1:0] rowcol_i,
  output logic             mem_req_o,
  output logic [LAT_W-1:0] lat_o
);
  logic             req_q, req_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             lat_en;

  assign lat_en = rise_i;

  always_comb begin
    req_d = req_q;
    lat_d = lat_q;
    if (rise_i) begin
      req_d = hit_i & ~io_page_i;
    end else if (!sync_i) begin
      req_d = 1'b0;
    end
    if (lat_en) lat_d = rowcol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lat_q <= '0;
    end else begin
      req_q <= req_d;
      lat_q <= lat_d;
    end
  end

  assign mem_req_o = req_q;
  assign lat_o     = lat_q;

  assert_io_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && io_page_i) |=> !mem_req_o);
  assert_drop_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> !mem_req_o);
  assert_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !rise_i) |=> $stable(mem_req_o));
  assert_lat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(lat_o));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_dec_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int FW      = FIELD_W,
  parameter int W_LSB   = WIDE_LSB,
  parameter int N_LSB   = NARROW_LSB,
  parameter int RC_LO   = ROWCOL_LO,
  parameter int RC_HI   = ROWCOL_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [AW-1:1]     addr_i,
  input  logic              wide_mode_i,
  input  logic [2*FW-1:0]   sw_on_i,
  input  logic              io_page_i,
  output logic              mem_req_o,
  output logic [RC_HI-RC_LO:0] rowcol_addr_o
);
  localparam int RC_W = RC_HI - RC_LO + 1;

  logic          rise;
  logic          hit;
  logic [FW-1:0] wide_field;
  logic [FW-1:0] narrow_field;
  logic [RC_W-1:0] rowcol;

  assign wide_field   = addr_i[W_LSB+FW-1:W_LSB];
  assign narrow_field = addr_i[N_LSB+FW-1:N_LSB];
  assign rowcol       = addr_i[RC_HI:RC_LO];

  ad_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  ad_slot_match #(.FIELD_W(FW)) u_match (
    .wide_i         (wide_mode_i),
    .wide_field_i   (wide_field),
    .narrow_field_i (narrow_field),
    .sw_on_i        (sw_on_i),
    .hit_o          (hit)
  );

  ad_capture #(.LAT_W(RC_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .sync_i    (sync_i),
    .hit_i     (hit),
    .io_page_i (io_page_i),
    .rowcol_i  (rowcol),
    .mem_req_o (mem_req_o),
    .lat_o     (rowcol_addr_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!mem_req_o && rowcol_addr_o == '0);
    end
  end

  assert_empty_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !wide_mode_i && (~sw_on_i[FW-1:0] > ~sw_on_i[2*FW-1:FW])) |=> !mem_req_o);
  assert_wide_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && wide_mode_i && !io_page_i && (wide_field == ~sw_on_i[FW-1:0])) |=> mem_req_o);
endmodule

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync;
  logic [21:1] addr;
  logic        wide;
  logic [7:0]  sw_on;
  logic        io;
  logic        req;
  logic [15:0] rowcol;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic        req;
    logic [15:0] lat;
    string       tag;
  } item_t;

  item_t sb[$];
  event  chk_ev;

  always #2 clk = ~clk;

  addr_window_decoder u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_i        (sync),
    .addr_i        (addr),
    .wide_mode_i   (wide),
    .sw_on_i       (sw_on),
    .io_page_i     (io),
    .mem_req_o     (req),
    .rowcol_addr_o (rowcol)
  );

  function automatic logic model_hit(logic [21:0] a, logic w, logic [7:0] son, logic iop);
    logic [7:0] code;
    code = ~son;
    if (iop) return 1'b0;
    if (w)   return a[21:18] == code[3:0];
    return (a[17:14] >= code[3:0]) && (a[17:14] <= code[7:4]);
  endfunction

  // monitor: pop expected item and compare at the falling edge
  initial begin
    forever begin
      @(chk_ev);
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (req !== it.req || rowcol !== it.lat) begin
          fails++;
          $display("FAIL %s: req=%0b lat=%h expected req=%0b lat=%h",
                   it.tag, req, rowcol, it.req, it.lat);
        end
      end
    end
  end

  task automatic txn(input logic [21:0] byte_a, input logic w, input logic [7:0] son,
                     input logic iop, input string tag);
    logic        e;
    logic [15:0] l;
    e = model_hit(byte_a, w, son, iop);
    l = byte_a[16:1];
    @(negedge clk);
    addr = byte_a[21:1]; wide = w; sw_on = son; io = iop; sync = 1'b1;
    @(negedge clk);
    sb.push_back('{e, l, tag});
    -> chk_ev;
    addr = ~byte_a[21:1]; io = 1'b0;          // R6: later changes are ignored
    @(negedge clk);
    sb.push_back('{e, l, {tag, " hold R6"}});
    -> chk_ev;
    sync = 1'b0;
    @(negedge clk);
    sb.push_back('{1'b0, l, {tag, " release R7 R8"}});
    -> chk_ev;
  endtask

  function automatic logic [7:0] win(input int s, input int e);
    return ~{e[3:0], s[3:0]};
  endfunction

  initial begin
    rst_n = 1'b0; sync = 1'b0; addr = '0; wide = 1'b1; sw_on = 8'hFF; io = 1'b0;
    repeat (3) @(negedge clk);
    sb.push_back('{1'b0, 16'h0, "reset R1"});
    -> chk_ev;
    rst_n = 1'b1;

    txn(22'h000246, 1'b1, 8'hFF, 1'b0, "all ON selects 0 R9 R2");
    txn(22'h15A5A4, 1'b1, ~8'h05, 1'b0, "wide slot hit R2");
    txn(22'h18A5A4, 1'b1, ~8'h05, 1'b0, "wide slot miss R2");
    txn(22'h140000, 1'b1, ~8'h05, 1'b1, "io page override R5");
    txn(22'h008000, 1'b0, win(2, 14), 1'b0, "window low edge R3");
    txn(22'h03BFFE, 1'b0, win(2, 14), 1'b0, "window last byte R3");
    txn(22'h03C000, 1'b0, win(2, 14), 1'b0, "window above end R3");
    txn(22'h004000, 1'b0, win(2, 14), 1'b0, "window below start R3");
    txn(22'h3D8000, 1'b0, win(2, 14), 1'b0, "upper bits ignored R3");
    txn(22'h018000, 1'b0, win(6, 6), 1'b0, "single block R3");
    txn(22'h018000, 1'b0, win(6, 6), 1'b1, "narrow io override R5");
    txn(22'h020000, 1'b0, win(9, 3), 1'b0, "start above end R4");
    txn(22'h00C000, 1'b0, win(9, 3), 1'b0, "start above end low R4");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule